// File: doc/BRIEF.md
# Low-Side Channel Control and Fault Encoder

This block sits between the serial command decoder and the output stages of a sixteen-channel low-side switch. It decides, every clock, which channels are driven on. The lower group of channels combines a parallel input pin with a serial control bit. A mode bit chooses whether the two are combined by AND or by OR. The upper group follows its serial control bit alone.

Each channel also reports three digital fault flags from its analog detectors: overload (short to supply), short to ground and open load. The block turns these into a two-bit status code per channel and packs the codes into diagnosis words for the serial output. Overload is latched and keeps the channel switched off until the diagnosis word holding that channel has been read. An active-low fault pin shows when any channel reports something other than normal.

The serial logic presents the word address on `rd_sel_i` and samples `diag_word_o`. At the end of the transfer it pulses `rd_stb_i` for one cycle.

Top module: `lsw_chan_ctrl`

## Requirements
- R1: While `rst_ni` is low, all outputs are off, `fault_no` is 1 and all overload latches are cleared. With no fault flags present after reset, both diagnosis words read 0xFFFF.
- R2: When `or_mode_i` is 0, channel c of the lower group (c < 8) is commanded on only if both `par_i[c]` and `ctrl_i[c]` are 1.
- R3: When `or_mode_i` is 1, channel c of the lower group is commanded on if `par_i[c]` or `ctrl_i[c]` is 1.
- R4: Channels 8 to 15 are commanded on by `ctrl_i[c]` alone. `par_i` and `or_mode_i` have no effect on them.
- R5: `out_en_o` is registered. It reflects the inputs present at the previous rising clock edge.
- R6: Status codes are 2'b11 normal, 2'b10 open load, 2'b01 short to ground and 2'b00 overload.
- R7: When several flags are active on one channel, overload is reported over short to ground, and short to ground over open load.
- R8: `rd_sel_i` = 0 selects channels 0 to 7 and `rd_sel_i` = 1 selects channels 8 to 15. Channel k of the selected word occupies bits [2k+1:2k] of `diag_word_o`.
- R9: An overload is latched. Its code stays 2'b00 after the flag drops until a `rd_stb_i` pulse with `rd_sel_i` addressing that channel's word. A strobe for the other word does not clear it. A strobe while the flag is still active does not clear it.
- R10: A channel whose overload flag is active, or whose overload latch is set, has `out_en_o` 0 on the next cycle, whatever its command.
- R11: `fault_no` is registered. It is 0 one cycle after any channel's code was not normal, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_i | input | 8 | Parallel command pins of the lower channel group |
| ctrl_i | input | 16 | Serial control bits, one per channel |
| or_mode_i | input | 1 | Combine mode for the lower group: 0 AND, 1 OR |
| ovl_i | input | 16 | Overload / short-to-supply detector flags |
| gnd_i | input | 16 | Short-to-ground detector flags |
| open_i | input | 16 | Open-load detector flags |
| rd_stb_i | input | 1 | One-cycle pulse: selected diagnosis word has been read |
| rd_sel_i | input | 1 | Diagnosis word address |
| out_en_o | output | 16 | Output stage enables |
| diag_word_o | output | 16 | Selected diagnosis word, two bits per channel |
| fault_no | output | 1 | Global fault indicator, active low |

## Verification
The bench builds the block with its default parameters: sixteen channels, eight with a parallel pin, and eight channels per diagnosis word. This gives two words, so a strobe can address the word that holds a latched overload or the other one. Both the pin-combined group and the serial-only group are present, so the mode bit's effect on one group and absence of effect on the other can be seen in the same cycle. A channel in the upper word carries all three flags at once. Its overload is then released, strobed from the wrong word, strobed while still active, and finally cleared.

// File: rtl/lsw_diag_pkg.sv
package lsw_diag_pkg;
  typedef enum logic [1:0] {
    DIAG_OVL  = 2'b00,
    DIAG_GND  = 2'b01,
    DIAG_OPEN = 2'b10,
    DIAG_OK   = 2'b11
  } diag_code_e;

  // priority: overload > short to ground > open load
  function automatic diag_code_e diag_encode(input logic ovl, input logic gnd, input logic opn);
    if (ovl)      return DIAG_OVL;
    else if (gnd) return DIAG_GND;
    else if (opn) return DIAG_OPEN;
    else          return DIAG_OK;
  endfunction
endpackage

// File: rtl/lsw_cmd_combine.sv
module lsw_cmd_combine #(
  parameter int N_CH  = 16,
  parameter int N_PAR = 8
) (
  input  logic [N_PAR-1:0] par_i,
  input  logic [N_CH-1:0]  ctrl_i,
  input  logic             or_mode_i,
  output logic [N_CH-1:0]  cmd_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    if (c < N_PAR) begin : g_par
      assign cmd_o[c] = or_mode_i ? (par_i[c] | ctrl_i[c]) : (par_i[c] & ctrl_i[c]);
    end else begin : g_spi
      assign cmd_o[c] = ctrl_i[c];
    end
  end
endmodule

// File: rtl/lsw_fault_enc.sv
module lsw_fault_enc
  import lsw_diag_pkg::*;
#(
  parameter int N_CH        = 16,
  parameter int CH_PER_WORD = 8,
  parameter int SEL_W       = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   ovl_i,
  input  logic [N_CH-1:0]   gnd_i,
  input  logic [N_CH-1:0]   open_i,
  input  logic              rd_stb_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [N_CH-1:0]   hold_o,
  output logic [2*N_CH-1:0] codes_o
);
  logic [N_CH-1:0] ovl_lat_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [SEL_W-1:0] WSEL = SEL_W'(c / CH_PER_WORD);
    logic clr;
    assign clr = rd_stb_i && (rd_sel_i == WSEL);

    // set wins over clear: a read while the flag persists keeps the latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           ovl_lat_q[c] <= 1'b0;
      else if (clr)          ovl_lat_q[c] <= ovl_i[c];
      else if (ovl_i[c])     ovl_lat_q[c] <= 1'b1;
    end

    assign hold_o[c]        = ovl_lat_q[c] | ovl_i[c];
    assign codes_o[2*c +: 2] = diag_encode(hold_o[c], gnd_i[c], open_i[c]);
  end
endmodule

// File: rtl/lsw_diag_pack.sv
module lsw_diag_pack #(
  parameter int N_CH        = 16,
  parameter int CH_PER_WORD = 8,
  parameter int SEL_W       = 1
) (
  input  logic [2*N_CH-1:0]        codes_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [2*CH_PER_WORD-1:0] word_o,
  output logic                     any_fault_o
);
  localparam int N_WORDS = N_CH / CH_PER_WORD;
  localparam int WORD_W  = 2 * CH_PER_WORD;

  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign words[w] = codes_i[WORD_W*w +: WORD_W];
  end

  always_comb begin
    word_o = '1;
    for (int w = 0; w < N_WORDS; w++) begin
      if (sel_i == SEL_W'(w)) word_o = words[w];
    end
  end

  // every normal code is 2'b11
  assign any_fault_o = ~(&codes_i);
endmodule

// File: rtl/lsw_chan_ctrl.sv
module lsw_chan_ctrl #(
  parameter int N_CH        = 16,
  parameter int N_PAR       = 8,
  parameter int CH_PER_WORD = 8,
  localparam int N_WORDS    = N_CH / CH_PER_WORD,
  localparam int SEL_W      = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_PAR-1:0]         par_i,
  input  logic [N_CH-1:0]          ctrl_i,
  input  logic                     or_mode_i,
  input  logic [N_CH-1:0]          ovl_i,
  input  logic [N_CH-1:0]          gnd_i,
  input  logic [N_CH-1:0]          open_i,
  input  logic                     rd_stb_i,
  input  logic [SEL_W-1:0]         rd_sel_i,
  output logic [N_CH-1:0]          out_en_o,
  output logic [2*CH_PER_WORD-1:0] diag_word_o,
  output logic                     fault_no
);
  logic [N_CH-1:0]   cmd;
  logic [N_CH-1:0]   hold;
  logic [2*N_CH-1:0] codes;
  logic              any_fault;
  logic [N_CH-1:0]   out_en_q;
  logic              fault_nq;

  lsw_cmd_combine #(.N_CH(N_CH), .N_PAR(N_PAR)) u_cmd (
    .par_i    (par_i),
    .ctrl_i   (ctrl_i),
    .or_mode_i(or_mode_i),
    .cmd_o    (cmd)
  );

  lsw_fault_enc #(.N_CH(N_CH), .CH_PER_WORD(CH_PER_WORD), .SEL_W(SEL_W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ovl_i   (ovl_i),
    .gnd_i   (gnd_i),
    .open_i  (open_i),
    .rd_stb_i(rd_stb_i),
    .rd_sel_i(rd_sel_i),
    .hold_o  (hold),
    .codes_o (codes)
  );

  lsw_diag_pack #(.N_CH(N_CH), .CH_PER_WORD(CH_PER_WORD), .SEL_W(SEL_W)) u_pack (
    .codes_i    (codes),
    .sel_i      (rd_sel_i),
    .word_o     (diag_word_o),
    .any_fault_o(any_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_en_q <= '0;
      fault_nq <= 1'b1;
    end else begin
      out_en_q <= cmd & ~hold;
      fault_nq <= ~any_fault;
    end
  end

  assign out_en_o = out_en_q;
  assign fault_no = fault_nq;
endmodule

// File: rtl/lsw_chan_ctrl_chk.sv
module lsw_chan_ctrl_chk #(
  parameter int N_CH        = 16,
  parameter int N_PAR       = 8,
  parameter int CH_PER_WORD = 8,
  parameter int SEL_W       = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_PAR-1:0]  par_i,
  input logic [N_CH-1:0]   ctrl_i,
  input logic              or_mode_i,
  input logic [N_CH-1:0]   ovl_i,
  input logic              rd_stb_i,
  input logic [SEL_W-1:0]  rd_sel_i,
  input logic [2*N_CH-1:0] codes_i,
  input logic [N_CH-1:0]   out_en_i,
  input logic              fault_ni
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_and_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!or_mode_i && par_i == '0) |=> out_en_i[N_PAR-1:0] == '0);

  p_spi_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[N_CH-1:N_PAR] == '0) |=> out_en_i[N_CH-1:N_PAR] == '0);

  p_ovl_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_i != '0) |=> (out_en_i & $past(ovl_i)) == '0);

  p_fault_pin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (fault_ni == $past(&codes_i)));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [SEL_W-1:0] WSEL = SEL_W'(c / CH_PER_WORD);

    p_ovl_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovl_i[c] |-> codes_i[2*c +: 2] == 2'b00);

    p_ovl_latch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(codes_i[2*c +: 2] == 2'b00) && !$past(rd_stb_i && rd_sel_i == WSEL))
      |-> codes_i[2*c +: 2] == 2'b00);
  end
endmodule

bind lsw_chan_ctrl lsw_chan_ctrl_chk #(
  .N_CH(N_CH), .N_PAR(N_PAR), .CH_PER_WORD(CH_PER_WORD), .SEL_W(SEL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .par_i    (par_i),
  .ctrl_i   (ctrl_i),
  .or_mode_i(or_mode_i),
  .ovl_i    (ovl_i),
  .rd_stb_i (rd_stb_i),
  .rd_sel_i (rd_sel_i),
  .codes_i  (codes),
  .out_en_i (out_en_o),
  .fault_ni (fault_no)
);

// File: tb/lsw_chan_ctrl_tb.sv
module lsw_chan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 16;
  localparam int N_PAR = 8;
  localparam int CPW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_PAR-1:0] par = '0;
  logic [N_CH-1:0] ctrl = '0, ovl = '0, gnd = '0, opn = '0;
  logic orm = 1'b0, stb = 1'b0;
  logic [0:0] sel = 1'b0;
  logic [N_CH-1:0] out_en;
  logic [2*CPW-1:0] dword;
  logic fault_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [N_CH-1:0]  out_en;
    logic             fault_n;
    logic [2*CPW-1:0] word;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [N_CH-1:0] lat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsw_chan_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .par_i(par), .ctrl_i(ctrl), .or_mode_i(orm),
    .ovl_i(ovl), .gnd_i(gnd), .open_i(opn), .rd_stb_i(stb), .rd_sel_i(sel),
    .out_en_o(out_en), .diag_word_o(dword), .fault_no(fault_n)
  );

  function automatic logic [1:0] enc(input logic o, input logic g, input logic p);
    if (o) return 2'b00;
    if (g) return 2'b01;
    if (p) return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] expv);
    n_checks++;
    if (got !== expv) begin
      n_errors++;
      $display("FAIL %s %s: got %h exp %h", req, what, got, expv);
    end
  endtask

  // drive one cycle of stimulus and queue the outputs expected after the next edge
  task automatic step(input logic [N_PAR-1:0] p, input logic [N_CH-1:0] c, input logic m,
                      input logic [N_CH-1:0] o, input logic [N_CH-1:0] g, input logic [N_CH-1:0] op,
                      input logic s, input logic sl, input string tag);
    exp_t e;
    logic [N_CH-1:0] cmd, lat_n;
    logic any;
    @(posedge clk); #4;
    par = p; ctrl = c; orm = m; ovl = o; gnd = g; opn = op; stb = s; sel = sl;
    any = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (i < N_PAR) cmd[i] = m ? (p[i] | c[i]) : (p[i] & c[i]);
      else           cmd[i] = c[i];
      if (enc(lat[i] | o[i], g[i], op[i]) != 2'b11) any = 1'b1;
      if (s && (i / CPW) == int'(sl)) lat_n[i] = o[i];
      else                            lat_n[i] = lat[i] | o[i];
    end
    e.out_en  = cmd & ~(lat | o);
    e.fault_n = ~any;
    for (int k = 0; k < CPW; k++) begin
      int ch = int'(sl) * CPW + k;
      e.word[2*k +: 2] = enc(lat_n[ch] | o[ch], g[ch], op[ch]);
    end
    lat = lat_n;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    exp_t e;
    string t;
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "out_en", 32'(out_en), 32'(e.out_en));
        check("R11", "fault_no", 32'(fault_n), 32'(e.fault_n));
        check(t, "diag_word", 32'(dword), 32'(e.word));
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL R5 watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    check("R1", "out_en in reset", 32'(out_en), 32'h0);
    check("R1", "fault_no in reset", 32'(fault_n), 32'h1);
    rst_n = 1'b1;
    // R1 R8: clean state, both words normal
    step('0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R1");
    step('0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b1, "R8");
    // R2 R5: AND combine
    step(8'h0F, 16'h003C, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R2");
    step(8'hFF, 16'h00A5, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R5");
    // R3: OR combine
    step(8'h0F, 16'h003C, 1'b1, '0, '0, '0, 1'b0, 1'b0, "R3");
    step(8'h80, 16'h0001, 1'b1, '0, '0, '0, 1'b0, 1'b0, "R3");
    // R4: upper group ignores pins and mode
    step(8'hFF, 16'hAA00, 1'b1, '0, '0, '0, 1'b0, 1'b1, "R4");
    step(8'hFF, 16'h5500, 1'b0, '0, '0, '0, 1'b0, 1'b1, "R4");
    // R6 R8: single flags per channel in word 0
    step('0, 16'h00FF, 1'b0, '0, 16'h0002, 16'h0004, 1'b0, 1'b0, "R6");
    step('0, '0, 1'b0, '0, 16'h4000, 16'h0800, 1'b0, 1'b1, "R8");
    // R7: combined flags; ch3 gnd+open, ch9 all three
    step(8'hFF, 16'hFFFF, 1'b1, 16'h0200, 16'h0208, 16'h0208, 1'b0, 1'b1, "R7");
    step(8'hFF, 16'hFFFF, 1'b1, 16'h0200, 16'h0208, 16'h0208, 1'b0, 1'b0, "R7");
    // R9 R10: flag gone, latch holds code and keeps ch9 off
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b0, 1'b1, "R10");
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b1, 1'b0, "R9");
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b0, 1'b1, "R9");
    step(8'hFF, 16'hFFFF, 1'b1, 16'h0200, '0, '0, 1'b1, 1'b1, "R9");
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b0, 1'b1, "R10");
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b1, 1'b1, "R9");
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b0, 1'b1, "R9");
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b0, 1'b1, "R10");
    // R10 R11: live overload on lower channel
    step(8'hFF, 16'hFFFF, 1'b1, 16'h0001, '0, '0, 1'b0, 1'b0, "R10");
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b1, 1'b0, "R11");
    step(8'hFF, 16'hFFFF, 1'b1, '0, '0, '0, 1'b0, 1'b0, "R11");
    step('0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R11");
    // R1: reset drops outputs and clears latches
    step(8'hFF, 16'hFFFF, 1'b1, 16'h8000, '0, '0, 1'b0, 1'b1, "R1");
    repeat (2) @(posedge clk);
    #4;
    ovl = '0;
    rst_n = 1'b0;
    #2;
    check("R1", "out_en after reset", 32'(out_en), 32'h0);
    check("R1", "fault_no after reset", 32'(fault_n), 32'h1);
    check("R1", "diag_word after reset", 32'(dword), 32'hFFFF);
    lat = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step('0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b1, "R1");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule